// File: doc/BRIEF.md
# Privilege-Split Branch Target Cache

This block predicts where a taken branch goes. The fetch unit presents a fetch PC and its current privilege level. In the same cycle the cache returns a hit flag and a predicted target. Entries are tagged with virtual addresses. Storage is divided into two halves: one serves kernel-mode fetch and the other serves user-mode fetch. The lookup privilege selects which half is searched.

Resolved branches write back their PC and target together with the privilege at which they ran. Each write goes only into the half that matches that privilege, and it replaces whatever entry already sat at that index.

Two invalidation inputs let software switches skip a full flush:
- A process switch clears only the user half, so kernel branch history stays in place.
- A virtual-machine switch clears both halves.

Each half is direct-mapped with 32 entries. The index is PC[6:2] and the tag is PC[31:7].

Top module: `btc_top`

## Requirements
- R1: After reset, every entry in both halves is invalid, and a lookup misses until an update has been accepted.
- R2: After an accepted update of (PC, privilege, target), a later lookup with the same PC and privilege hits and returns that target, as long as no flush or overwrite has intervened.
- R3: An entry written at one privilege never hits a lookup at the other privilege. Privilege is coded as 1 = kernel, 0 = user.
- R4: Lookup uses PC[6:2] as the index and compares PC[31:7] as the tag. PC[1:0] has no effect, and a PC with the same index but a different tag misses.
- R5: An update to an occupied index overwrites the previous entry in that half. The old PC then misses and the new PC hits.
- R6: When a process-switch flush is asserted, every user entry becomes invalid and kernel entries are preserved.
- R7: When a virtual-machine flush is asserted, every entry in both halves becomes invalid.
- R8: A lookup in the same cycle as a flush of its own half returns a miss. A lookup of the half that is not being flushed is unaffected.
- R9: An update in the same cycle as a flush of its target half is discarded. An update to the other half in that cycle is kept.
- R10: If a lookup and an update touch the same half and index in the same cycle, the lookup returns the contents held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_kern | input | 1 | Lookup privilege (1 = kernel) |
| lk_hit | output | 1 | Lookup hit |
| lk_target | output | 32 | Predicted target, meaningful when lk_hit is 1 |
| up_en | input | 1 | Update request from a resolved branch |
| up_pc | input | 32 | Branch PC being written |
| up_kern | input | 1 | Privilege of the resolved branch (1 = kernel) |
| up_target | input | 32 | Resolved branch target |
| flush_proc | input | 1 | Process-switch flush; clears the user half |
| flush_vm | input | 1 | Virtual-machine flush; clears both halves |

## Verification
The checker watches four behaviours on every cycle:
- the empty state after reset;
- the forced miss when a lookup coincides with a flush of its half;
- the cleared state in the cycle after either flush;
- an immediate hit with the right target on the cycle after an accepted update.

Some behaviours can only be shown by the bench's scenarios, driven against a reference model:
- survival of kernel entries across a process flush;
- the privilege separation;
- tag aliasing at a shared index;
- overwrite;
- dropped updates during a flush;
- the read-before-write ordering.

// File: rtl/btc_pkg.sv
package btc_pkg;

    typedef enum logic {
        PRIV_USER   = 1'b0,
        PRIV_KERNEL = 1'b1
    } priv_e;

    localparam int NUM_HALVES = 2;
    localparam int PC_OFS_W   = 2;

endpackage

// File: rtl/btc_half.sv
module btc_half #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 5,
    parameter int OFS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_tgt,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_tgt
);
    localparam int TAG_W = PC_W - IDX_W - OFS_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [TAG_W-1:0] rd_tag;
    logic             wr_go;
    logic             unused_low;

    assign wr_idx     = wr_pc[OFS_W +: IDX_W];
    assign rd_idx     = rd_pc[OFS_W +: IDX_W];
    assign wr_tag     = wr_pc[PC_W-1 -: TAG_W];
    assign rd_tag     = rd_pc[PC_W-1 -: TAG_W];
    assign wr_go      = wr_en && !clr;
    assign unused_low = ^{wr_pc[OFS_W-1:0], rd_pc[OFS_W-1:0]};

    // Valid bits: cleared in bulk by reset or flush; a flush beats a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (wr_go) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Payload arrays carry no reset; validity guards them.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    // Combinational read sees pre-edge contents, so it reads before the write lands.
    always_comb begin
        rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag) && !clr;
        rd_tgt = tgt_q[rd_idx];
    end

endmodule

// File: rtl/btc_top.sv
module btc_top #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_kern,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_en,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_kern,
    input  logic [PC_W-1:0] up_target,
    input  logic            flush_proc,
    input  logic            flush_vm
);
    import btc_pkg::*;

    logic [NUM_HALVES-1:0] half_hit;
    logic [PC_W-1:0]       half_tgt [NUM_HALVES];

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam priv_e HALF_PRIV = (h == 0) ? PRIV_USER : PRIV_KERNEL;
        logic half_clr;
        logic half_wr;

        if (HALF_PRIV == PRIV_KERNEL) begin : g_kclr
            assign half_clr = flush_vm;
        end else begin : g_uclr
            assign half_clr = flush_vm || flush_proc;
        end

        assign half_wr = up_en && (priv_e'(up_kern) == HALF_PRIV);

        btc_half #(
            .PC_W  (PC_W),
            .IDX_W (IDX_W),
            .OFS_W (PC_OFS_W)
        ) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (half_clr),
            .wr_en  (half_wr),
            .wr_pc  (up_pc),
            .wr_tgt (up_target),
            .rd_pc  (lk_pc),
            .rd_hit (half_hit[h]),
            .rd_tgt (half_tgt[h])
        );
    end

    always_comb begin
        if (priv_e'(lk_kern) == PRIV_KERNEL) begin
            lk_hit    = half_hit[1];
            lk_target = half_tgt[1];
        end else begin
            lk_hit    = half_hit[0];
            lk_target = half_tgt[0];
        end
    end

endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_kern,
    input logic            lk_hit,
    input logic [PC_W-1:0] lk_target,
    input logic            up_en,
    input logic [PC_W-1:0] up_pc,
    input logic            up_kern,
    input logic [PC_W-1:0] up_target,
    input logic            flush_proc,
    input logic            flush_vm
);
    logic seen_q;
    logic unused_low;

    assign unused_low = ^{lk_pc[1:0], up_pc[1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n)     seen_q <= 1'b0;
        else if (up_en) seen_q <= 1'b1;
    end

    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !lk_hit);

    p_write_then_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !flush_vm && !(flush_proc && !up_kern)) |=>
        ((lk_pc[PC_W-1:2] == $past(up_pc[PC_W-1:2])) && (lk_kern == $past(up_kern))
          && !flush_vm && !(flush_proc && !lk_kern))
        |-> (lk_hit && (lk_target == $past(up_target))));

    p_proc_flush_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_proc && !up_en) |=> (!lk_kern |-> !lk_hit));

    p_vm_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vm |=> !lk_hit);

    p_flush_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_vm || (flush_proc && !lk_kern)) |-> !lk_hit);

endmodule

bind btc_top btc_checker #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_pc      (lk_pc),
    .lk_kern    (lk_kern),
    .lk_hit     (lk_hit),
    .lk_target  (lk_target),
    .up_en      (up_en),
    .up_pc      (up_pc),
    .up_kern    (up_kern),
    .up_target  (up_target),
    .flush_proc (flush_proc),
    .flush_vm   (flush_vm)
);

// File: tb/btc_top_tb.sv
module btc_top_tb;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] lk_pc, up_pc, up_target, lk_target;
    logic            lk_kern, lk_hit, up_en, up_kern, flush_proc, flush_vm;

    int checks = 0;
    int failures = 0;

    bit          mval [2][32];
    logic [24:0] mtag [2][32];
    logic [31:0] mtgt [2][32];

    always #10 clk = ~clk;

    btc_top u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_kern(lk_kern),
        .lk_hit(lk_hit), .lk_target(lk_target), .up_en(up_en), .up_pc(up_pc),
        .up_kern(up_kern), .up_target(up_target), .flush_proc(flush_proc),
        .flush_vm(flush_vm)
    );

    function automatic bit half_cleared(bit k, bit fp, bit fv);
        return fv || (fp && !k);
    endfunction

    function automatic bit exp_hit(logic [31:0] pc, bit k, bit fp, bit fv);
        return mval[k][pc[6:2]] && (mtag[k][pc[6:2]] == pc[31:7]) && !half_cleared(k, fp, fv);
    endfunction

    task automatic model_clear();
        for (int h = 0; h < 2; h++)
            for (int i = 0; i < 32; i++) mval[h][i] = 1'b0;
    endtask

    task automatic cyc(input logic [31:0] lpc, input bit lk, input bit ue,
                       input logic [31:0] upc, input bit uk, input logic [31:0] utg,
                       input bit fp, input bit fv, input bit chk, input string req);
        bit          eh;
        logic [31:0] et;
        @(negedge clk);
        lk_pc = lpc; lk_kern = lk; up_en = ue; up_pc = upc; up_kern = uk;
        up_target = utg; flush_proc = fp; flush_vm = fv;
        #2;
        eh = exp_hit(lpc, lk, fp, fv);
        et = mtgt[lk][lpc[6:2]];
        if (chk) begin
            checks++;
            if (lk_hit !== eh || (eh && lk_target !== et)) begin
                failures++;
                $display("FAIL %s: hit=%0b exp=%0b target=%h exp=%h", req, lk_hit, eh, lk_target, et);
            end
        end
        @(posedge clk);
        for (int h = 0; h < 2; h++)
            if (half_cleared(h[0], fp, fv))
                for (int i = 0; i < 32; i++) mval[h][i] = 1'b0;
        if (ue && !half_cleared(uk, fp, fv)) begin
            mval[uk][upc[6:2]] = 1'b1;
            mtag[uk][upc[6:2]] = upc[31:7];
            mtgt[uk][upc[6:2]] = utg;
        end
    endtask

    task automatic look(input logic [31:0] pc, input bit k, input string req);
        cyc(pc, k, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b1, req);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] A, B, C, rp, rt;
        bit rk, ru, rfp, rfv;
        void'($urandom(32'd1234));
        A = 32'h0000_1004; B = A + 32'h80; C = 32'h0040_2010;
        rst_n = 1'b0; lk_pc = '0; lk_kern = 0; up_en = 0; up_pc = '0; up_kern = 0;
        up_target = '0; flush_proc = 0; flush_vm = 0;
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        look(A, 0, "R1 user empty after reset");
        look(A, 1, "R1 kernel empty after reset");
        // R10: lookup while writing the same index sees the old (empty) state
        cyc(A, 0, 1, A, 0, 32'hAAAA_0000, 0, 0, 1, "R10 read-before-write empty");
        look(A, 0, "R2 hit after update");
        look(A, 1, "R3 user entry invisible to kernel");
        look(A | 32'h3, 0, "R4 low PC bits ignored");
        look(B, 0, "R4 same index other tag misses");
        cyc(A, 1, 1, A, 1, 32'hBBBB_0000, 0, 0, 0, "");
        look(A, 1, "R3 kernel entry hit");
        look(A, 0, "R3 user entry still own target");
        cyc(A, 0, 1, B, 0, 32'hCCCC_0000, 0, 0, 1, "R10 read-before-write old entry");
        look(A, 0, "R5 overwritten PC misses");
        look(B, 0, "R5 new PC hits");
        cyc(A, 1, 0, '0, 0, '0, 1, 0, 1, "R8 kernel lookup during process flush");
        look(B, 0, "R6 user entry cleared");
        look(A, 1, "R6 kernel entry preserved");
        cyc(B, 0, 1, B, 0, 32'hDDDD_0000, 0, 0, 0, "");
        cyc(B, 0, 0, '0, 0, '0, 1, 0, 1, "R8 user lookup during process flush");
        cyc(A, 1, 1, B, 0, 32'hEEEE_0000, 1, 0, 0, "");
        look(B, 0, "R9 user update during process flush dropped");
        cyc(A, 1, 1, C, 1, 32'h1111_0000, 1, 0, 0, "");
        look(C, 1, "R9 kernel update during process flush kept");
        cyc(A, 1, 0, '0, 0, '0, 0, 1, 1, "R8 kernel lookup during VM flush");
        look(A, 1, "R7 kernel entry A cleared");
        look(C, 1, "R7 kernel entry C cleared");

        for (int n = 0; n < 600; n++) begin
            rp  = {23'h0, $urandom_range(3, 0) == 0 ? 2'd1 : 2'd0, 5'($urandom), 2'($urandom)};
            rk  = 1'($urandom);
            ru  = ($urandom_range(3, 0) != 0);
            rt  = $urandom;
            rfp = ($urandom_range(31, 0) == 0);
            rfv = ($urandom_range(63, 0) == 0);
            cyc(rp, rk, ru, {rp[31:7], 5'($urandom_range(3, 0)), 2'b00}, 1'($urandom), rt,
                rfp, rfv, 1'b1, "R2 random traffic");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule